// File: doc/BRIEF.md
# Protected Return Address Stack

This block holds subroutine return addresses in dedicated storage, separate from the data stack that holds local variables and buffers. Because ordinary loads and stores never reach this storage, an overrun of a buffer in a stack frame cannot corrupt a return target. The execution unit drives four command strobes: call, return, explicit push and explicit pop. It also drives a data word and a 3-bit type tag with each command.

A call stores the data word as the return address. A return removes the top entry and presents it as the branch target. The explicit push and pop commands are the only other ways to change the contents. An explicit push is accepted only when its data carries the address tag. Illegal requests raise a fault and leave the stack untouched. Illegal requests are: overflow, underflow, a non-address push, and more than one strobe in a cycle. Every result is registered and appears one cycle after the command.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset, `fault_o` and `target_valid_o` are 0, `fault_kind_o` is 3'd0 (none), and the stack is empty.
- R2: A call stores `data_i` whatever the value of `tag_i`. A return pops the most recent entry. One cycle after the return strobe, `target_o` carries that entry and `target_valid_o` is 1 for that cycle.
- R3: An explicit push stores `data_i` only when `tag_i` is 3'd1 (address). Any other tag gives `fault_kind_o` = 3'd3 and leaves the stack unchanged. This tag fault is reported even when the stack is full.
- R4: A call or push to a stack that holds DEPTH entries gives `fault_kind_o` = 3'd1 (overflow) and leaves the stack unchanged.
- R5: A return or pop on an empty stack gives `fault_kind_o` = 3'd2 (underflow). `target_valid_o` stays 0 in that case.
- R6: If two or more of the four strobes are high in one cycle, `fault_kind_o` = 3'd4 results and no entry is added or removed.
- R7: An explicit pop delivers the top entry on `target_o` with the same timing as a return.
- R8: `fault_o` is 1 exactly in the cycle after a refused command and 0 otherwise. `target_o` holds its last popped value while no pop occurs.
- R9: Up to DEPTH entries (16 by default) are retained and come back in reverse order of entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| call_i | input | 1 | Call strobe, implicit push of data_i |
| ret_i | input | 1 | Return strobe, implicit pop |
| push_i | input | 1 | Explicit push strobe |
| pop_i | input | 1 | Explicit pop strobe |
| data_i | input | DATA_W | Return address or push data |
| tag_i | input | 3 | Type tag of data_i (3'd1 = address) |
| target_o | output | DATA_W | Popped return address |
| target_valid_o | output | 1 | target_o updated this cycle |
| fault_o | output | 1 | Command refused in previous cycle |
| fault_kind_o | output | 3 | 0 none, 1 overflow, 2 underflow, 3 bad tag, 4 multiple strobes |

## Verification
The hardest state to reach is a completely full stack. Reaching it takes sixteen back-to-back calls with distinct addresses. At that point the bench tries an overflowing call and a wrongly tagged push, then drains every entry to confirm the contents and order are intact. Refusals that must not change state are proved through later pops: each one is followed by returns that must yield the earlier top and then an underflow.

// File: rtl/rstack_pkg.sv
package rstack_pkg;
  typedef enum logic [2:0] {
    TAG_NULL  = 3'd0,
    TAG_ADDR  = 3'd1,
    TAG_VALUE = 3'd2,
    TAG_INSTR = 3'd3,
    TAG_REF   = 3'd4
  } tag_e;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_OVER  = 3'd1,
    FLT_UNDER = 3'd2,
    FLT_TAG   = 3'd3,
    FLT_MULTI = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } op_e;
endpackage

// File: rtl/rstack_cmd_decode.sv
module rstack_cmd_decode
  import rstack_pkg::*;
(
  input  logic       call_i,
  input  logic       ret_i,
  input  logic       push_i,
  input  logic       pop_i,
  input  logic [2:0] tag_i,
  input  logic       full_i,
  input  logic       empty_i,
  output op_e        op_o,
  output fault_e     fault_o
);
  logic [2:0] n_strobe;

  assign n_strobe = {2'b0, call_i} + {2'b0, ret_i} + {2'b0, push_i} + {2'b0, pop_i};

  always_comb begin
    op_o    = OP_NONE;
    fault_o = FLT_NONE;
    if (n_strobe > 3'd1) begin
      fault_o = FLT_MULTI;
    end else if (push_i) begin
      // tag is checked before occupancy
      if (tag_i != TAG_ADDR) fault_o = FLT_TAG;
      else if (full_i)       fault_o = FLT_OVER;
      else                   op_o    = OP_PUSH;
    end else if (call_i) begin
      if (full_i) fault_o = FLT_OVER;
      else        op_o    = OP_PUSH;
    end else if (ret_i || pop_i) begin
      if (empty_i) fault_o = FLT_UNDER;
      else         op_o    = OP_POP;
    end
  end
endmodule

// File: rtl/rstack_store.sv
module rstack_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [CW-1:0]     count_o,
  output logic              full_o,
  output logic              empty_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [CW-1:0]     count_q;
  logic [CW-1:0]     top_idx;
  logic [PW-1:0]     wr_ptr;
  logic [PW-1:0]     rd_ptr;

  assign top_idx = count_q - CW'(1);
  assign wr_ptr  = count_q[PW-1:0];
  assign rd_ptr  = top_idx[PW-1:0];
  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign count_o = count_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i) begin
      if (push_i && wr_ptr == PW'(g)) mem_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q  <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= pop_i;
      if (push_i) begin
        count_q <= count_q + CW'(1);
      end else if (pop_i) begin
        count_q <= top_idx;
        rdata_o <= mem_q[rd_ptr];
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH)); // R4
  AST_NO_PUSH_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o); // R4
  AST_NO_POP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R5
  AST_PUSH_GROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> count_q == $past(count_q) + CW'(1)); // R9
  AST_POP_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |=> rvalid_o); // R2
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import rstack_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [2:0]        tag_i,
  output logic [DATA_W-1:0] target_o,
  output logic              target_valid_o,
  output logic              fault_o,
  output logic [2:0]        fault_kind_o
);
  op_e           op;
  fault_e        flt;
  logic          full, empty;
  logic [CW-1:0] count;

  rstack_cmd_decode u_dec (
    .call_i  (call_i),
    .ret_i   (ret_i),
    .push_i  (push_i),
    .pop_i   (pop_i),
    .tag_i   (tag_i),
    .full_i  (full),
    .empty_i (empty),
    .op_o    (op),
    .fault_o (flt)
  );

  rstack_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (op == OP_PUSH),
    .pop_i    (op == OP_POP),
    .wdata_i  (data_i),
    .rdata_o  (target_o),
    .rvalid_o (target_valid_o),
    .count_o  (count),
    .full_o   (full),
    .empty_o  (empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_o      <= 1'b0;
      fault_kind_o <= FLT_NONE;
    end else begin
      fault_o      <= (flt != FLT_NONE);
      fault_kind_o <= flt;
    end
  end

  AST_FAULT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $stable(count)); // R6
  AST_FAULT_NO_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !target_valid_o); // R5
  AST_MULTI_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((call_i && ret_i) || (push_i && pop_i)) |=> fault_kind_o == FLT_MULTI); // R6
  AST_TAG_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !call_i && !ret_i && !pop_i && tag_i != TAG_ADDR)
      |=> fault_kind_o == FLT_TAG && $stable(count)); // R3
  AST_FULL_CALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !ret_i && !push_i && !pop_i && full) |=> fault_kind_o == FLT_OVER); // R4
endmodule

// File: tb/ret_addr_stack_test.sv
`timescale 1ns/1ps
module ret_addr_stack_test;
  localparam int DW = 32;
  localparam int DEPTH = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          call = 0, ret = 0, push = 0, pop = 0;
  logic [DW-1:0] data = '0;
  logic [2:0]    tag = '0;
  logic [DW-1:0] target;
  logic          tvalid, fault;
  logic [2:0]    fkind;
  int            n_run = 0, n_fail = 0;
  bit            done = 0;

  always #2.5 clk = ~clk;

  ret_addr_stack #(.DATA_W(DW), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .call_i(call), .ret_i(ret), .push_i(push),
    .pop_i(pop), .data_i(data), .tag_i(tag), .target_o(target),
    .target_valid_o(tvalid), .fault_o(fault), .fault_kind_o(fkind)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one command at a falling edge; outputs are sampled one cycle later
  task automatic issue(input logic c, input logic r, input logic pu, input logic po,
                       input logic [DW-1:0] d, input logic [2:0] t);
    @(negedge clk);
    call = c; ret = r; push = pu; pop = po; data = d; tag = t;
    @(negedge clk);
    call = 0; ret = 0; push = 0; pop = 0; data = '0; tag = '0;
  endtask

  task automatic expect_pop(input string req, input logic [DW-1:0] v);
    chk({req, " target"}, target, v);
    chk({req, " valid"}, tvalid, 1);
    chk({req, " fault"}, fault, 0);
  endtask

  task automatic expect_fault(input string req, input logic [2:0] k);
    chk({req, " fault"}, fault, 1);
    chk({req, " kind"}, fkind, k);
    chk({req, " valid"}, tvalid, 0);
  endtask

  task automatic t_reset;
    chk("R1 fault", fault, 0);
    chk("R1 valid", tvalid, 0);
    chk("R1 kind", fkind, 0);
    issue(0, 1, 0, 0, 0, 0);
    expect_fault("R1 empty after reset", 3'd2);
  endtask

  task automatic t_call_ret;
    issue(1, 0, 0, 0, 32'h100, 3'd1);
    chk("R2 call no fault", fault, 0);
    chk("R2 call no valid", tvalid, 0);
    issue(1, 0, 0, 0, 32'h200, 3'd2); // call ignores tag
    issue(0, 1, 0, 0, 0, 0);
    expect_pop("R2 ret top", 32'h200);
    issue(0, 1, 0, 0, 0, 0);
    expect_pop("R2 ret next", 32'h100);
    issue(0, 1, 0, 0, 0, 0);
    expect_fault("R5 ret empty", 3'd2);
  endtask

  task automatic t_push_pop;
    issue(0, 0, 1, 0, 32'h55, 3'd1);
    chk("R3 addr push ok", fault, 0);
    issue(0, 0, 0, 1, 0, 0);
    expect_pop("R7 pop", 32'h55);
    issue(0, 0, 0, 1, 0, 0);
    expect_fault("R5 pop empty", 3'd2);
  endtask

  task automatic t_bad_tag;
    issue(0, 0, 1, 0, 32'h11, 3'd1);
    issue(0, 0, 1, 0, 32'h22, 3'd2);
    expect_fault("R3 value tag", 3'd3);
    issue(0, 0, 1, 0, 32'h33, 3'd0);
    expect_fault("R3 null tag", 3'd3);
    issue(0, 0, 0, 1, 0, 0);
    expect_pop("R3 stack unchanged", 32'h11);
    issue(0, 0, 0, 1, 0, 0);
    expect_fault("R3 nothing extra", 3'd2);
  endtask

  task automatic t_full;
    for (int i = 0; i < DEPTH; i++) issue(1, 0, 0, 0, 32'h1000 + i, 3'd1);
    chk("R9 full no fault", fault, 0);
    issue(1, 0, 0, 0, 32'hDEAD, 3'd1);
    expect_fault("R4 call full", 3'd1);
    issue(0, 0, 1, 0, 32'hBEEF, 3'd1);
    expect_fault("R4 push full", 3'd1);
    issue(0, 0, 1, 0, 32'hBEEF, 3'd2);
    expect_fault("R3 tag before full", 3'd3);
    for (int i = DEPTH - 1; i >= 0; i--) begin
      issue(0, 1, 0, 0, 0, 0);
      expect_pop("R9 drain order", 32'h1000 + i);
    end
    issue(0, 1, 0, 0, 0, 0);
    expect_fault("R4 no extra entry", 3'd2);
  endtask

  task automatic t_multi;
    issue(1, 0, 0, 0, 32'h7, 3'd1);
    issue(1, 1, 0, 0, 32'h8, 3'd1);
    expect_fault("R6 call+ret", 3'd4);
    issue(0, 0, 1, 1, 32'h9, 3'd1);
    expect_fault("R6 push+pop", 3'd4);
    issue(1, 0, 1, 0, 32'hA, 3'd1);
    expect_fault("R6 call+push", 3'd4);
    issue(0, 1, 0, 0, 0, 0);
    expect_pop("R6 stack unchanged", 32'h7);
    issue(0, 1, 0, 0, 0, 0);
    expect_fault("R6 nothing added", 3'd2);
  endtask

  task automatic t_pulse;
    issue(1, 0, 0, 0, 32'h44, 3'd1);
    issue(0, 1, 0, 0, 0, 0);
    expect_pop("R8 setup", 32'h44);
    issue(0, 1, 0, 0, 0, 0);
    chk("R8 fault set", fault, 1);
    @(negedge clk);
    chk("R8 fault clears", fault, 0);
    chk("R8 kind clears", fkind, 0);
    chk("R8 valid low idle", tvalid, 0);
    chk("R8 target held", target, 32'h44);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_call_ret();
    t_push_pop();
    t_bad_tag();
    t_full();
    t_multi();
    t_pulse();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule